// File: doc/BRIEF.md
# Operand Bypass Select and Load-Use Interlock

This block decides, every cycle, where the two ALU operands of the instruction in the execute stage of an in-order, single-issue, five-stage integer pipeline come from. It also decides whether the data written by a store in the memory stage must be taken from the instruction one stage ahead of it. It compares the source register numbers of the instructions in decode and execute with the destination numbers, write enables and load flags held in the three downstream pipeline registers. From these it produces multiplexer selects for the datapath and a stall request for the front end.

Two bypass levels cover back-to-back and one-apart dependences. The younger producer wins when both levels match. A dependence two or more instructions back is not seen here: the register file writes early in the cycle and reads late, so a consumer in decode already reads the new value. The one case bypassing cannot cover is an ALU consumer directly behind a load. For that case the block holds the program counter and the decode register for one cycle and turns the execute-stage slot into a bubble. One cycle later the loaded value arrives through the writeback bypass.

Top module: `fwd_hazard_unit`

## Requirements
- R1: `fwd_a` / `fwd_b` equal 2'b01 (take the EX/MEM ALU result) when the EX/MEM entry writes (`mem_we`=1), is not a load, has a nonzero destination, and that destination equals `ex_rs1` / `ex_rs2`. A load in EX/MEM never supplies this path.
- R2: Without an R1 match, the select is 2'b10 (take the MEM/WB value) when `wb_we`=1 and `wb_rd` is nonzero and equals the source. Otherwise it is 2'b00 (register file operand).
- R3: When EX/MEM and MEM/WB both match the same source, the select is 2'b01.
- R4: Register number 0 never causes a forward, a store-data forward or a stall.
- R5: An entry whose write enable is low never matches, for forwarding or for the interlock.
- R6: `hold` and `bubble` are both 1, in the same cycle and combinationally, when ID/EX holds a writing load with a nonzero destination that equals `id_rs1`, or equals `id_rs2` while the decode instruction is not a store.
- R7: A store in decode whose data register (`id_rs2`) is the only match with a load in ID/EX does not stall. `st_fwd` is 1 exactly when `mem_is_store`=1, `wb_we`=1, and `mem_data_src` is nonzero and equal to `wb_rd`.
- R8: The interlock lasts at most one cycle. In the cycle after `hold` was 1, `hold` and `bubble` are 0 whatever the inputs.
- R9: Decode sources matching only EX/MEM or MEM/WB destinations never stall.
- R10: After reset with all inputs low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the one-cycle interlock limit |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs1 | input | AW | First source of the decode instruction |
| id_rs2 | input | AW | Second source of the decode instruction |
| id_is_store | input | 1 | Decode instruction is a store (rs2 is store data) |
| ex_rs1 | input | AW | First source of the execute instruction |
| ex_rs2 | input | AW | Second source of the execute instruction |
| ex_rd | input | AW | ID/EX destination |
| ex_we | input | 1 | ID/EX writes a register |
| ex_is_load | input | 1 | ID/EX holds a load |
| mem_rd | input | AW | EX/MEM destination |
| mem_we | input | 1 | EX/MEM writes a register |
| mem_is_load | input | 1 | EX/MEM holds a load |
| mem_is_store | input | 1 | EX/MEM holds a store |
| mem_data_src | input | AW | Store-data register of the EX/MEM store |
| wb_rd | input | AW | MEM/WB destination |
| wb_we | input | 1 | MEM/WB writes a register |
| fwd_a | output | 2 | ALU operand A select |
| fwd_b | output | 2 | ALU operand B select |
| st_fwd | output | 1 | Store data taken from MEM/WB |
| hold | output | 1 | Freeze PC and IF/ID |
| bubble | output | 1 | Insert bubble into ID/EX |

## Verification
The bench builds the block with AW=3, so each register number is one of eight values. Random register numbers then collide often. Double matches, register-0 matches and load-use coincidences each arise in a large share of random cycles instead of rarely. Directed sequences add a load-use pattern held for three cycles, which shows the stall, its forced release, and its return.

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_is_store,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_is_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic          mem_is_load,
  input  logic          mem_is_store,
  input  logic [AW-1:0] mem_data_src,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_we,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          st_fwd,
  output logic          hold,
  output logic          bubble
);

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_MEM = 2'b01;
  localparam logic [1:0] SEL_WB  = 2'b10;
  localparam logic [AW-1:0] ZERO = '0;

  logic mem_live, wb_live, ld_live, load_use, hold_q;

  assign mem_live = mem_we && !mem_is_load && (mem_rd != ZERO);
  assign wb_live  = wb_we && (wb_rd != ZERO);
  assign ld_live  = ex_we && ex_is_load && (ex_rd != ZERO);

  function automatic logic [1:0] pick(input logic [AW-1:0] src,
                                      input logic m_ok, input logic [AW-1:0] m_rd,
                                      input logic w_ok, input logic [AW-1:0] w_rd);
    if (m_ok && m_rd == src)      return SEL_MEM;
    else if (w_ok && w_rd == src) return SEL_WB;
    else                          return SEL_RF;
  endfunction

  assign fwd_a  = pick(ex_rs1, mem_live, mem_rd, wb_live, wb_rd);
  assign fwd_b  = pick(ex_rs2, mem_live, mem_rd, wb_live, wb_rd);
  assign st_fwd = mem_is_store && wb_live && (wb_rd == mem_data_src);

  assign load_use = ld_live &&
                    ((id_rs1 == ex_rd) || (!id_is_store && id_rs2 == ex_rd));
  assign hold   = load_use && !hold_q;
  assign bubble = hold;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold;

  p_single_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !hold);

  p_zero_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs1 == ZERO) |-> (fwd_a == SEL_RF));

  p_unwritten_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we && !wb_we) |-> (fwd_a == SEL_RF && fwd_b == SEL_RF && !st_fwd));

  p_needs_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (ex_is_load && ex_we && bubble));

  p_store_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (id_is_store && id_rs1 != ex_rd) |-> !hold);

  p_far_no_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_is_load |-> !hold);

endmodule

// File: tb/test_fwd_hazard_unit.sv
`timescale 1ns/1ps
module test_fwd_hazard_unit;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_data_src, wb_rd;
  logic id_is_store, ex_we, ex_is_load, mem_we, mem_is_load, mem_is_store, wb_we;
  logic [1:0] fwd_a, fwd_b;
  logic st_fwd, hold, bubble;

  int n_vec = 0, n_bad = 0;
  logic model_hq = 1'b0;
  bit finished = 0;

  always #2 clk = ~clk;

  fwd_hazard_unit #(.AW(AW)) i_fwd_hazard_unit (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2), .id_is_store(id_is_store),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_we(ex_we), .ex_is_load(ex_is_load),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_is_load(mem_is_load), .mem_is_store(mem_is_store),
    .mem_data_src(mem_data_src), .wb_rd(wb_rd), .wb_we(wb_we),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .st_fwd(st_fwd), .hold(hold), .bubble(bubble));

  function automatic logic [1:0] exp_sel(input logic [AW-1:0] src);
    if (src == 0) return 2'b00;
    if (mem_we && !mem_is_load && mem_rd == src) return 2'b01;
    if (wb_we && wb_rd == src) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic exp_st();
    return mem_is_store && wb_we && mem_data_src != 0 && wb_rd == mem_data_src;
  endfunction

  function automatic logic exp_hold();
    if (!rst_n && 0) return 1'b0;
    return !model_hq && ex_is_load && ex_we && ex_rd != 0 &&
           (id_rs1 == ex_rd || (!id_is_store && id_rs2 == ex_rd));
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) model_hq <= 1'b0;
    else        model_hq <= exp_hold();

  task automatic clr();
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_data_src, wb_rd} = '0;
    {id_is_store, ex_we, ex_is_load, mem_we, mem_is_load, mem_is_store, wb_we} = '0;
  endtask

  task automatic check(input string tag);
    logic [6:0] got, exp;
    #1;
    got = {fwd_a, fwd_b, st_fwd, hold, bubble};
    exp = {exp_sel(ex_rs1), exp_sel(ex_rs2), exp_st(), exp_hold(), exp_hold()};
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got a/b/st/hold/bub=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4242));
    clr();
    repeat (3) @(posedge clk);
    @(negedge clk); check("R10 during reset");
    rst_n = 1'b1;
    @(negedge clk); check("R10 after reset");

    @(negedge clk); clr(); ex_rs1 = 3; mem_rd = 3; mem_we = 1; check("R1 EX/MEM to A");
    @(negedge clk); clr(); ex_rs2 = 6; mem_rd = 6; mem_we = 1; check("R1 EX/MEM to B");
    @(negedge clk); clr(); ex_rs1 = 6; mem_rd = 6; mem_we = 1; mem_is_load = 1; check("R1 load in EX/MEM ignored");
    @(negedge clk); clr(); ex_rs2 = 5; wb_rd = 5; wb_we = 1; check("R2 MEM/WB to B");
    @(negedge clk); clr(); ex_rs1 = 4; ex_rs2 = 4; mem_rd = 4; mem_we = 1; wb_rd = 4; wb_we = 1; check("R3 younger wins");
    @(negedge clk); clr(); ex_rs1 = 0; ex_rs2 = 0; mem_rd = 0; mem_we = 1; wb_rd = 0; wb_we = 1;
      ex_rd = 0; ex_we = 1; ex_is_load = 1; mem_is_store = 1; check("R4 register 0 quiet");
    @(negedge clk); clr(); ex_rs1 = 2; mem_rd = 2; wb_rd = 2; ex_rd = 1; ex_is_load = 1; id_rs1 = 1; check("R5 no write enable");
    @(negedge clk); clr(); ex_rd = 2; ex_we = 1; ex_is_load = 1; id_rs1 = 2; check("R6 load-use rs1");
    @(negedge clk); check("R8 released after one cycle");
    @(negedge clk); check("R6 stall returns");
    @(negedge clk); id_rs1 = 7; id_rs2 = 2; check("R8 released again");
    @(negedge clk); check("R6 load-use rs2");
    @(negedge clk); clr(); ex_rd = 2; ex_we = 1; ex_is_load = 1; id_is_store = 1; id_rs1 = 5; id_rs2 = 2; check("R7 store data no stall");
    @(negedge clk); clr(); mem_is_store = 1; mem_data_src = 6; wb_rd = 6; wb_we = 1; check("R7 store data forward");
    @(negedge clk); wb_we = 0; check("R7 store data no forward");
    @(negedge clk); clr(); id_rs1 = 3; id_rs2 = 5; mem_rd = 3; mem_we = 1; wb_rd = 5; wb_we = 1; ex_rd = 1; ex_we = 1; check("R9 far producers no stall");

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      id_rs1 = AW'($urandom); id_rs2 = AW'($urandom); ex_rs1 = AW'($urandom); ex_rs2 = AW'($urandom);
      ex_rd = AW'($urandom); mem_rd = AW'($urandom); wb_rd = AW'($urandom); mem_data_src = AW'($urandom);
      {id_is_store, ex_we, ex_is_load, mem_we, mem_is_load, mem_is_store, wb_we} = 7'($urandom);
      check("random R1 R2 R3 R6 R7 R8");
    end
    finish_up();
  end
endmodule